// File: doc/BRIEF.md
# Serial Frame Aligner for SONET/SDH Byte Streams

This block takes a recovered NRZ serial stream, one bit for each clock on which `bit_en` is high, and packs it into bytes. The first bit received becomes the byte's most significant bit. A free-running divide-by-eight bit counter sets the byte boundary. Each time a byte completes, the block raises `byte_stb` for one clock and presents the byte on `pdata`.

While the out-of-frame input `oof` is held high, the block hunts for the frame alignment word: three consecutive A1 bytes (8'hF6) followed at once by three A2 bytes (8'h28), at any bit offset. When it finds the word, it emits the third A2 byte on the spot, raises `frame_pulse` with it, and restarts the byte boundary at the next bit. `oof` is a level. For as long as it stays high, every later alignment word re-aligns the boundary again. While `oof` is low, the current boundary is kept and no frame is reported.

Top module: `serial_frame_aligner`

## Requirements
- R1: Bits are packed most significant bit first: in an emitted byte, bit 7 is the earliest bit received and bit 0 is the most recent.
- R2: While `oof` is low, a byte is emitted after every 8 enabled bits, and the boundary does not move even if the alignment word passes through.
- R3: A frame is detected only on 48 contiguous bits equal to 8'hF6, 8'hF6, 8'hF6, 8'h28, 8'h28, 8'h28, in that order, at any bit offset. Two A1 bytes followed by three A2 bytes is not a frame.
- R4: When a frame is detected with `oof` high, the byte ending on the detecting bit is emitted at once, and that byte is 8'h28. The next byte is made of the 8 enabled bits that follow.
- R5: `frame_pulse` goes high together with the strobe of the third A2 byte. It stays high until the next strobe, then drops.
- R6: `frame_pulse` is raised only if `oof` is high on the clock where the detecting bit is taken in.
- R7: While `oof` stays high after a frame has been found, a later alignment word at a different bit offset moves the boundary again and raises a new pulse.
- R8: `byte_stb` is a one-clock pulse in the clock after the enabled bit that completes a byte. `pdata` and `frame_pulse` change only together with `byte_stb`.
- R9: Clocks with `bit_en` low neither shift data nor advance the bit count.
- R10: Synchronous active-high `rst` clears the bit history, selects boundary offset 0, and drives `pdata`, `byte_stb` and `frame_pulse` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `sdata` as one serial bit |
| sdata | input | 1 | Serial NRZ data bit |
| oof | input | 1 | Out-of-frame level; high enables hunting |
| pdata | output | 8 | Last emitted byte |
| byte_stb | output | 1 | One-clock strobe for a new byte |
| frame_pulse | output | 1 | High for the byte period of the third A2 byte |

## Verification
The ordinary divide-by-eight byte completion and the detection of an alignment word can fall on the same enabled bit. If the stream is already on the right boundary, the re-alignment emits the byte the counter would have emitted anyway. If it is not, the re-alignment cuts a byte short. The bench sends alignment words both on the current boundary and at offsets of 3 and 5 bits, with idle clocks between bits. A scoreboard model compares every strobed byte and its pulse flag, so a doubled strobe, a lost strobe or a byte on the wrong boundary shows up as a mismatch.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] A1_DEF = 8'hF6;
   localparam logic [BYTE_W-1:0] A2_DEF = 8'h28;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sfa_shift.sv
module sfa_shift #(
   parameter int unsigned HIST = 48
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            bit_en,
   input  logic            sdata,
   output logic [HIST-1:0] hist
);
   always_ff @(posedge clk) begin
      if (rst)
         hist <= '0;
      else if (bit_en)
         hist <= {hist[HIST-2:0], sdata};
   end
endmodule

// File: rtl/sfa_match.sv
module sfa_match #(
   parameter int unsigned        REPS   = 3,
   parameter sfa_pkg::byte_t     A1_PAT = sfa_pkg::A1_DEF,
   parameter sfa_pkg::byte_t     A2_PAT = sfa_pkg::A2_DEF,
   localparam int unsigned       BW     = sfa_pkg::BYTE_W,
   localparam int unsigned       NBYTES = 2 * REPS,
   localparam int unsigned       WIN    = NBYTES * BW
) (
   input  logic [WIN-1:0] window,
   output logic           hit
);
   logic [NBYTES-1:0] byte_ok;

   // byte slot 0 holds the newest bits; the newest REPS slots must be A2
   for (genvar g = 0; g < NBYTES; g++) begin : g_slot
      if (g < REPS) begin : g_a2
         assign byte_ok[g] = (window[g*BW +: BW] == A2_PAT);
      end else begin : g_a1
         assign byte_ok[g] = (window[g*BW +: BW] == A1_PAT);
      end
   end

   assign hit = &byte_ok;
endmodule

// File: rtl/sfa_aligner.sv
module sfa_aligner #(
   localparam int unsigned BW  = sfa_pkg::BYTE_W,
   localparam int unsigned CW  = $clog2(BW)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           bit_en,
   input  logic           realign,
   input  sfa_pkg::byte_t cur_byte,
   output sfa_pkg::byte_t pdata,
   output logic           byte_stb,
   output logic           frame_pulse
);
   logic [CW-1:0] bit_cnt;
   logic          cnt_wrap;
   logic          byte_done;

   assign cnt_wrap  = (bit_cnt == CW'(BW - 1));
   assign byte_done = bit_en && (cnt_wrap || realign);

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt <= '0;
      end else if (bit_en) begin
         if (byte_done)
            bit_cnt <= '0;
         else
            bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pdata       <= '0;
         byte_stb    <= 1'b0;
         frame_pulse <= 1'b0;
      end else begin
         byte_stb <= byte_done;
         if (byte_done) begin
            pdata       <= cur_byte;
            frame_pulse <= realign;
         end
      end
   end
endmodule

// File: rtl/serial_frame_aligner.sv
module serial_frame_aligner #(
   parameter int unsigned    REPS   = 3,
   parameter sfa_pkg::byte_t A1_PAT = sfa_pkg::A1_DEF,
   parameter sfa_pkg::byte_t A2_PAT = sfa_pkg::A2_DEF
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       bit_en,
   input  logic       sdata,
   input  logic       oof,
   output logic [7:0] pdata,
   output logic       byte_stb,
   output logic       frame_pulse
);
   localparam int unsigned BW   = sfa_pkg::BYTE_W;
   localparam int unsigned WIN  = 2 * REPS * BW;
   localparam int unsigned HIST = WIN - 1;

   if (REPS < 1 || REPS > 16) begin : g_bad_reps
      $error("serial_frame_aligner: REPS out of range");
   end
   if (A1_PAT == A2_PAT) begin : g_bad_pat
      $error("serial_frame_aligner: A1 and A2 patterns must differ");
   end

   logic [HIST-1:0] hist;
   logic [WIN-1:0]  window;
   logic            pat_hit;
   logic            realign;

   sfa_shift #(.HIST(HIST)) u_shift (
      .clk    (clk),
      .rst    (rst),
      .bit_en (bit_en),
      .sdata  (sdata),
      .hist   (hist)
   );

   assign window = {hist, sdata};

   sfa_match #(.REPS(REPS), .A1_PAT(A1_PAT), .A2_PAT(A2_PAT)) u_match (
      .window (window),
      .hit    (pat_hit)
   );

   assign realign = oof && pat_hit;

   sfa_aligner u_align (
      .clk         (clk),
      .rst         (rst),
      .bit_en      (bit_en),
      .realign     (realign),
      .cur_byte    (window[BW-1:0]),
      .pdata       (pdata),
      .byte_stb    (byte_stb),
      .frame_pulse (frame_pulse)
   );
endmodule

// File: rtl/sfa_chk.sv
module sfa_chk (
   input logic       clk,
   input logic       rst,
   input logic       bit_en,
   input logic       oof,
   input logic [7:0] pdata,
   input logic       byte_stb,
   input logic       frame_pulse
);
   // R8: a strobe needs an enabled bit in the clock before it
   p_stb_after_bit_r8: assert property (@(posedge clk) disable iff (rst)
      byte_stb |-> $past(bit_en));

   // R8: the output byte is held between strobes
   p_data_held_r8: assert property (@(posedge clk) disable iff (rst)
      !byte_stb |-> $stable(pdata));

   // R5: the pulse only changes level together with a strobe
   p_pulse_held_r5: assert property (@(posedge clk) disable iff (rst)
      !byte_stb |-> $stable(frame_pulse));

   // R6: a newly raised pulse needs oof high when the detecting bit came in
   p_pulse_needs_oof_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(frame_pulse) |-> $past(oof));

   // R9: with no enabled bit there is no strobe in the next clock
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> !byte_stb);
endmodule

bind serial_frame_aligner sfa_chk u_sfa_chk (
   .clk         (clk),
   .rst         (rst),
   .bit_en      (bit_en),
   .oof         (oof),
   .pdata       (pdata),
   .byte_stb    (byte_stb),
   .frame_pulse (frame_pulse)
);

// File: tb/tb_serial_frame_aligner.sv
module tb_serial_frame_aligner;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [47:0] FRAME_WORD = {8'hF6, 8'hF6, 8'hF6, 8'h28, 8'h28, 8'h28};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bit_en = 1'b0;
   logic       sdata = 1'b0;
   logic       oof = 1'b0;
   logic [7:0] pdata;
   logic       byte_stb;
   logic       frame_pulse;

   int tests = 0;
   int fails = 0;
   int fp_seen = 0;
   int fp_exp  = 0;
   bit done = 1'b0;

   logic [47:0] m_hist = '0;
   int          m_cnt  = 0;
   logic [8:0]  exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_frame_aligner dut (
      .clk(clk), .rst(rst), .bit_en(bit_en), .sdata(sdata), .oof(oof),
      .pdata(pdata), .byte_stb(byte_stb), .frame_pulse(frame_pulse)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: one bit, plus the model derived from R1-R4 (R9: idle clocks are not modelled)
   task automatic send_bit(input logic b);
      logic [47:0] win;
      bit hit;
      @(negedge clk);
      bit_en = 1'b1;
      sdata  = b;
      win = {m_hist[46:0], b};
      hit = oof && (win == FRAME_WORD);
      m_hist = win;
      if (m_cnt == 7 || hit) begin
         exp_q.push_back({hit, win[7:0]});
         if (hit) fp_exp++;
         m_cnt = 0;
      end else begin
         m_cnt++;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_en = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] v, input int gap);
      for (int i = 7; i >= 0; i--) begin
         send_bit(v[i]);
         if (gap > 0) idle(gap);
      end
   endtask

   task automatic send_frame(input int gap);
      for (int i = 47; i >= 0; i--) begin
         send_bit(FRAME_WORD[i]);
         if (gap > 0) idle(gap);
      end
   endtask

   // monitor: scoreboard compare on each strobe
   always @(negedge clk) begin
      if (!rst && byte_stb) begin
         if (frame_pulse) fp_seen++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected strobe", pdata, 0);
         end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            check(pdata == e[7:0], "R1/R2/R4 byte value", pdata, e[7:0]);
            check(frame_pulse == e[8], "R5/R6 frame pulse", frame_pulse, e[8]);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         check(1'b0, "watchdog expired", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int fp_before;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(pdata == 8'h00 && !byte_stb && !frame_pulse, "R10 reset outputs",
            {pdata, byte_stb, frame_pulse}, 0);
      @(negedge clk);
      rst = 1'b0;

      // R1, R2: oof low, free-running bytes, MSB first
      send_byte(8'hA5, 0);
      send_byte(8'h3C, 0);
      send_byte(8'h81, 1);
      idle(3);
      check(exp_q.size() == 0, "R2 bytes drained", exp_q.size(), 0);

      // R2, R6: frame at offset 3 with oof low is ignored
      fp_before = fp_seen;
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      send_frame(0);
      send_byte(8'h11, 0);
      send_byte(8'h22, 0);
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      idle(3);
      check(fp_seen == fp_before, "R6 no pulse while oof low", fp_seen, fp_before);
      check(exp_q.size() == 0, "R2 boundary kept", exp_q.size(), 0);

      // R3: two A1 then three A2 is not a frame
      oof = 1'b1;
      fp_before = fp_seen;
      send_byte(8'h00, 0);
      send_byte(8'hF6, 0); send_byte(8'hF6, 0);
      send_byte(8'h28, 0); send_byte(8'h28, 0); send_byte(8'h28, 0);
      send_byte(8'h5A, 0);
      idle(3);
      check(fp_seen == fp_before, "R3 short A1 run rejected", fp_seen, fp_before);

      // R4, R5: frame at offset 5, idle gaps between bits, then payload on new boundary
      fp_before = fp_seen;
      for (int i = 0; i < 5; i++) send_bit(1'b0);
      send_frame(1);
      send_byte(8'hC3, 1);
      send_byte(8'h7E, 0);
      idle(3);
      check(fp_seen == fp_before + 1, "R4 frame recovered", fp_seen, fp_before + 1);

      // R7: oof kept high, next frame at offset 3 realigns again
      fp_before = fp_seen;
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      send_frame(0);
      send_byte(8'h96, 0);
      send_byte(8'h0F, 0);
      idle(3);
      check(fp_seen == fp_before + 1, "R7 second realign", fp_seen, fp_before + 1);

      // frame already on boundary: counter wrap and detection on the same bit
      fp_before = fp_seen;
      send_frame(0);
      send_byte(8'hE7, 0);
      idle(3);
      check(fp_seen == fp_before + 1, "R4 aligned frame single strobe", fp_seen, fp_before + 1);

      // R9: idle clocks produce no strobe
      idle(20);
      check(!byte_stb, "R9 no strobe when idle", byte_stb, 0);

      // R10: reset mid-stream clears outputs
      send_bit(1'b1); send_bit(1'b0);
      @(negedge clk);
      bit_en = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      check(pdata == 8'h00 && !frame_pulse && !byte_stb, "R10 reset clears",
            {pdata, frame_pulse, byte_stb}, 0);
      @(negedge clk);
      rst = 1'b0;
      m_hist = '0;
      m_cnt = 0;
      oof = 1'b0;
      send_byte(8'h4B, 0);
      idle(3);
      check(exp_q.size() == 0, "R10 offset zero after reset", exp_q.size(), 0);
      check(fp_seen == fp_exp, "R5 total pulses", fp_seen, fp_exp);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule